// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a standard-mode two-wire serial bus (I2C). It holds sixteen 8-bit configuration registers and presents all 128 bits in parallel to the logic around it. A bus master reaches the registers through a register pointer. Each write transfer first loads the pointer and then carries data bytes. A read transfer returns bytes starting at the pointer.

The block samples both bus lines on the system clock through synchronizers. It finds START and STOP conditions and the clock edges in those samples. It answers only the 7-bit device address 1011X00, where X follows a strap input, so two copies can share one bus. Every byte moves the pointer up by one, and the pointer wraps from 15 to 0, so a burst longer than sixteen bytes starts over at the wrapped address. A data byte takes effect in its register when the slave acknowledges it; the block does not wait for STOP. SDA is driven open-drain through a single enable that pulls the line low.

Top module: `i2c_cfg_regfile`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1011X00, with X equal to `addr_sel`. The acknowledge is SDA held low during the ninth clock.
- R2: Any other address, including the all-zero general call, gets no acknowledge. Every byte after it until the next START is ignored: `sda_oe` stays low and no register changes.
- R3: In a write transfer (R/W bit = 0), the first byte after the address loads its low four bits into the pointer. Each later byte is acknowledged and stored in the register at the pointer.
- R4: A data byte appears on `cfg_bits` when the slave acknowledges it, before any STOP. Register k occupies bits [8k+7:8k].
- R5: A STOP or a repeated START that arrives before a data byte's eighth bit is complete discards that byte. The register and the pointer are left unchanged.
- R6: The pointer advances by one after each byte written or read and wraps from 15 to 0. Bytes beyond the sixteenth of a burst overwrite the registers from the wrapped address.
- R7: In a read transfer (R/W bit = 1), the slave sends the register at the pointer MSB first. It goes on with the next register while the master acknowledges. After a NACK it releases SDA. The pointer keeps its value between transfers.
- R8: Reset clears all sixteen registers to zero and releases SDA.
- R9: `sda_oe` changes only while SCL is low, and never within HOLD_CLKS system clocks of an SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 1 | Strap that supplies device-address bit 2 |
| sda_oe | output | 1 | When high, pulls SDA low |
| cfg_bits | output | 128 | All registers side by side, register k at [8k+7:8k] |

## Verification
The hardest case to produce from the pins is a transfer broken off partway through a data byte. A STOP or a repeated START must then leave both the target register and the pointer unchanged. The bench master can send any number of bits of a byte before it issues the bus condition. The interrupted write is followed by a write that uses the pointer, or by a read without a pointer phase, so a pointer that moved would show up as a wrong value at a known address. Wraparound is reached with a twenty-byte write burst and a twenty-byte read burst, both started near the top of the pointer range.

// File: rtl/cfgi2c_pkg.sv
`timescale 1ns/1ps
package cfgi2c_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_PTR, S_WDATA, S_ACK, S_RDATA, S_RACK
  } bus_state_t;

  typedef enum logic [1:0] {
    AK_PTR, AK_WR, AK_RD
  } ack_next_t;

  // Compare the received address byte with the base address; the strap replaces one bit.
  function automatic logic dev_match(input logic [7:0] rx, input logic [6:0] base,
                                     input logic strap, input int pos);
    logic [6:0] want;
    want = base;
    want[pos] = strap;
    return rx[7:1] == want;
  endfunction

  // Read/write flag from the address byte.
  function automatic logic is_read(input logic [7:0] rx);
    return rx[0];
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
`timescale 1ns/1ps
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic scl_fall_late,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;
  logic [HOLD_CLKS-1:0] fall_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync  <= '1;
      sda_sync  <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      fall_pipe <= '0;
    end else begin
      scl_sync  <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync  <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q     <= scl_s;
      sda_q     <= sda_s;
      fall_pipe <= {fall_pipe[HOLD_CLKS-2:0], scl_fall};
    end
  end

  assign scl_s         = scl_sync[SYNC_STAGES-1];
  assign sda_s         = sda_sync[SYNC_STAGES-1];
  assign scl_rise      = scl_s & ~scl_q;
  assign scl_fall      = ~scl_s & scl_q;
  assign scl_fall_late = fall_pipe[HOLD_CLKS-1];
  assign start_det     = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det      = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank #(
  parameter int NUM_REGS = 16,
  parameter int BYTE_W   = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [PTR_W-1:0]           waddr,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic [PTR_W-1:0]           raddr,
  output logic [BYTE_W-1:0]          rdata,
  output logic [NUM_REGS*BYTE_W-1:0] flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else if (we && waddr == PTR_W'(g)) r_q <= wdata;
    end
    assign flat[g*BYTE_W +: BYTE_W] = r_q;
  end

  assign rdata = flat[raddr*BYTE_W +: BYTE_W];
endmodule

// File: rtl/i2c_cfg_regfile.sv
`timescale 1ns/1ps
module i2c_cfg_regfile #(
  parameter int         NUM_REGS    = 16,
  parameter logic [6:0] DEV_BASE    = 7'h58,
  parameter int         STRAP_POS   = 2,
  parameter int         SYNC_STAGES = 2,
  parameter int         HOLD_CLKS   = 4,
  localparam int        BYTE_W      = 8,
  localparam int        PTR_W       = $clog2(NUM_REGS),
  localparam int        CFG_W       = NUM_REGS * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_sel,
  output logic             sda_oe,
  output logic [CFG_W-1:0] cfg_bits
);
  import cfgi2c_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, scl_fall_late, start_det, stop_det;
  bus_state_t         state;
  ack_next_t          ack_next;
  logic [BYTE_W-1:0]  rx_sh, tx_sh, rd_byte;
  logic [3:0]         bit_cnt;
  logic [PTR_W-1:0]   ptr;
  logic               mst_ack;
  logic               byte_done, reg_we, addr_hit, in_ack, in_idle, bus_evt;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CLKS(HOLD_CLKS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .scl_fall_late(scl_fall_late), .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign reg_we    = (state == S_WDATA) && byte_done;
  assign addr_hit  = dev_match(rx_sh, DEV_BASE, addr_sel, STRAP_POS);
  assign in_ack    = (state == S_ACK);
  assign in_idle   = (state == S_IDLE);
  assign bus_evt   = start_det | stop_det;

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(ptr), .wdata(rx_sh),
    .raddr(ptr), .rdata(rd_byte), .flat(cfg_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ack_next <= AK_PTR;
      rx_sh    <= '0;
      tx_sh    <= '0;
      bit_cnt  <= '0;
      ptr      <= '0;
      mst_ack  <= 1'b0;
    end else if (start_det) begin
      state   <= S_ADDR;
      bit_cnt <= '0;
    end else if (stop_det) begin
      state   <= S_IDLE;
      bit_cnt <= '0;
    end else begin
      case (state)
        S_ADDR, S_PTR, S_WDATA: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == S_ADDR) begin
              if (addr_hit) begin
                state    <= S_ACK;
                ack_next <= is_read(rx_sh) ? AK_RD : AK_PTR;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_PTR) begin
              ptr      <= rx_sh[PTR_W-1:0];
              state    <= S_ACK;
              ack_next <= AK_WR;
            end else begin
              ptr      <= ptr + 1'b1;
              state    <= S_ACK;
              ack_next <= AK_WR;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            case (ack_next)
              AK_RD: begin
                state <= S_RDATA;
                tx_sh <= rd_byte;
              end
              AK_PTR:  state <= S_PTR;
              default: state <= S_WDATA;
            endcase
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              state   <= S_RACK;
              bit_cnt <= '0;
              ptr     <= ptr + 1'b1;
            end else begin
              tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (mst_ack) begin
              state <= S_RDATA;
              tx_sh <= rd_byte;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // The SDA drive changes only a few clocks after the SCL falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sda_oe <= 1'b0;
    else if (bus_evt)       sda_oe <= 1'b0;
    else if (scl_fall_late) sda_oe <= in_ack || (state == S_RDATA && !tx_sh[BYTE_W-1]);
  end
endmodule

// File: rtl/cfgi2c_checker.sv
`timescale 1ns/1ps
module cfgi2c_checker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             reg_we,
  input logic             in_ack,
  input logic             in_idle,
  input logic             bus_evt,
  input logic [PTR_W-1:0] ptr
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R9

  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_s || $past(bus_evt))); // R9

  AST_COMMIT_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> in_ack); // R4

  AST_COMMIT_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_s); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (PTR_W'(ptr - $past(ptr)) == PTR_W'(1))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe); // R2
endmodule

bind i2c_cfg_regfile cfgi2c_checker #(.PTR_W(PTR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .reg_we(reg_we),
  .in_ack(in_ack), .in_idle(in_idle), .bus_evt(bus_evt), .ptr(ptr)
);

// File: tb/test_i2c_cfg_regfile.sv
`timescale 1ns/1ps
module test_i2c_cfg_regfile;
  localparam int Q    = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_low = 1'b0;
  logic addr_sel = 1'b0;
  logic sda_oe;
  logic [127:0] cfg_bits;
  wire  sda_line = !(sda_low | sda_oe);

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  int since_fall = 0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  logic [7:0] mdl [16];

  always #2.5 clk = ~clk;

  i2c_cfg_regfile i_i2c_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .cfg_bits(cfg_bits)
  );

  // R9 monitor: watch when the slave drive changes relative to the bench SCL
  always @(negedge clk) begin
    if (prev_scl && !scl_m) since_fall = 0;
    else if (!scl_m) since_fall = since_fall + 1;
    if (rst_n && sda_oe != prev_oe && (scl_m || since_fall < HOLD)) viol = viol + 1;
    prev_oe  = sda_oe;
    prev_scl = scl_m;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wq(Q);
    sda_low = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_low = 1'b1; wq(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wq(Q);
    sda_low = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_low = 1'b0; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl_m = 1'b0; wq(Q);
      sda_low = !b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    scl_m = 1'b0; wq(Q);
    sda_low = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = !sda_line; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wq(Q);
      sda_low = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
    end
    scl_m = 1'b0; wq(Q);
    sda_low = give_ack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
  endtask

  function automatic logic [7:0] pat_a(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] pat_b(input int i);
    return 8'((i * 53 + 145) & 255);
  endfunction

  function automatic logic [7:0] reg_of(input int k);
    return cfg_bits[k*8 +: 8];
  endfunction

  task automatic check_all(input string tag);
    for (int k = 0; k < 16; k++)
      chk(reg_of(k) == mdl[k], tag, {24'd0, reg_of(k)}, {24'd0, mdl[k]});
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin
      @(posedge clk);
      wd++;
    end
    n_fail++;
    n_chk++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    for (int k = 0; k < 16; k++) mdl[k] = 8'h00;
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R8: reset state
    chk(cfg_bits == 128'd0, "R8 regs clear at reset", cfg_bits[31:0], 0);
    chk(sda_oe == 1'b0, "R8 sda released at reset", {31'd0, sda_oe}, 0);

    // R1/R2: sweep of all 7-bit addresses with strap low; only 0x58 acks
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk(ack == (a == 8'h58), (a == 8'h58) ? "R1 address ack" : "R2 foreign address",
          {31'd0, ack}, {31'd0, a == 8'h58});
      bus_stop();
    end

    // R1: strap high moves the address to 0x5C
    addr_sel = 1'b1;
    bus_start(); send_byte(8'hB8, ack); bus_stop();
    chk(ack, "R1 strap high address ack", {31'd0, ack}, 1);
    bus_start(); send_byte(8'hB0, ack); bus_stop();
    chk(!ack, "R1 strap high old address", {31'd0, ack}, 0);
    addr_sel = 1'b0;

    // R2: general call and the bytes after it are ignored
    bus_start();
    send_byte(8'h00, ack);
    chk(!ack, "R2 general call not acked", {31'd0, ack}, 0);
    send_byte(8'h03, ack);
    chk(!ack, "R2 follow byte not acked", {31'd0, ack}, 0);
    send_byte(8'hAA, ack);
    chk(!ack, "R2 data after general call not acked", {31'd0, ack}, 0);
    bus_stop();
    check_all("R2 regs untouched");

    // R3/R4: write all sixteen registers, each visible at its ack
    bus_start();
    send_byte(8'hB0, ack);
    send_byte(8'h00, ack);
    chk(ack, "R3 pointer byte acked", {31'd0, ack}, 1);
    for (int i = 0; i < 16; i++) begin
      send_byte(pat_a(i), ack);
      mdl[i] = pat_a(i);
      chk(ack, "R3 data byte acked", {31'd0, ack}, 1);
      chk(reg_of(i) == mdl[i], "R4 committed before stop", {24'd0, reg_of(i)}, {24'd0, mdl[i]});
    end
    bus_stop();
    check_all("R3 full write");

    // R6: twenty-byte burst from 13 wraps and overwrites
    bus_start();
    send_byte(8'hB0, ack);
    send_byte(8'h0D, ack);
    for (int i = 0; i < 20; i++) begin
      send_byte(pat_b(i), ack);
      mdl[(13 + i) % 16] = pat_b(i);
      chk(reg_of((13 + i) % 16) == mdl[(13 + i) % 16], "R6 wrapped write",
          {24'd0, reg_of((13 + i) % 16)}, {24'd0, mdl[(13 + i) % 16]});
    end
    bus_stop();
    check_all("R6 after wrap burst");

    // R5: STOP partway through a data byte
    bus_start();
    send_byte(8'hB0, ack);
    send_byte(8'h05, ack);
    send_byte(8'h3C, ack);
    mdl[5] = 8'h3C;
    send_bits(8'hFF, 4);
    bus_stop();
    chk(reg_of(5) == 8'h3C, "R5 full byte kept", {24'd0, reg_of(5)}, 32'h3C);
    chk(reg_of(6) == mdl[6], "R5 partial byte dropped at stop", {24'd0, reg_of(6)}, {24'd0, mdl[6]});

    // R5: repeated START partway through; pointer must still be 9
    bus_start();
    send_byte(8'hB0, ack);
    send_byte(8'h09, ack);
    send_bits(8'h5A, 5);
    bus_start();
    send_byte(8'hB1, ack);
    recv_byte(1'b0, rb);
    bus_stop();
    chk(rb == mdl[9], "R5 partial byte dropped at restart, pointer kept", {24'd0, rb}, {24'd0, mdl[9]});
    check_all("R5 regs after aborts");

    // R7: single-byte read from every pointer value
    for (int p = 0; p < 16; p++) begin
      bus_start();
      send_byte(8'hB0, ack);
      send_byte(8'(p), ack);
      bus_start();
      send_byte(8'hB1, ack);
      chk(ack, "R7 read address acked", {31'd0, ack}, 1);
      recv_byte(1'b0, rb);
      chk(rb == mdl[p], "R7 random read", {24'd0, rb}, {24'd0, mdl[p]});
      chk(sda_oe == 1'b0, "R7 released after nack", {31'd0, sda_oe}, 0);
      bus_stop();
    end

    // R6/R7: twenty-byte read burst from 10 wraps
    bus_start();
    send_byte(8'hB0, ack);
    send_byte(8'h0A, ack);
    bus_start();
    send_byte(8'hB1, ack);
    for (int i = 0; i < 20; i++) begin
      recv_byte(i != 19, rb);
      chk(rb == mdl[(10 + i) % 16], "R6 wrapped read", {24'd0, rb}, {24'd0, mdl[(10 + i) % 16]});
    end
    chk(sda_oe == 1'b0, "R7 released after last nack", {31'd0, sda_oe}, 0);
    bus_stop();

    // R7: read with no pointer phase continues from pointer 14
    bus_start();
    send_byte(8'hB1, ack);
    recv_byte(1'b0, rb);
    bus_stop();
    chk(rb == mdl[14], "R7 pointer kept across transfers", {24'd0, rb}, {24'd0, mdl[14]});

    // R9: drive timing over the whole run
    chk(viol == 0, "R9 sda changes only while scl low after hold", viol, 0);

    // R8: reset clears registers written earlier
    rst_n = 1'b0;
    wq(3);
    chk(cfg_bits == 128'd0, "R8 regs clear after reset", cfg_bits[31:0], 0);
    rst_n = 1'b1;
    wq(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule